// File: doc/BRIEF.md
# Slot-Age Flow Priority Demoter

This block chooses an egress queue for every arriving packet from the age of the packet's flow. Age is the number of time-slot boundaries that have passed since the flow's first packet. Short flows finish while they still sit in the fast queues, and long flows sink step by step to the slowest queue. This approximates shortest-job-first scheduling without any knowledge of flow sizes. Every flow that starts in the same slot gets the same birth slot, so the whole group is demoted together.

Each packet presents a hashed flow key. The low bits of the key index a direct-mapped flow table and the high bits are a tag stored in the entry. When a packet finds no valid entry for its flow, or finds an entry with a different tag, the block writes a fresh entry stamped with the current slot and sends the packet to the top queue. No controller is involved. A free-running slot tick advances a modular slot counter. Each entry has a sticky bit that pins it to the last queue before the counter can wrap past its birth slot. A synchronous clear empties the table and restarts slot numbering.

Top module: `flow_age_demoter`

## Requirements
- R1: After reset, `out_valid` is low, the table is empty and the slot count is 0, so the first packet of any flow is classified as new.
- R2: A packet accepted in cycle t (`in_valid` high, `clear` low) produces `out_valid` high with its queue in cycle t+2. One packet can be accepted every cycle, and `out_valid` is never high without such a packet.
- R3: A packet whose flow has no valid table entry gets queue 0, the highest priority, and its flow is installed with the current slot as birth slot.
- R4: A packet of a known flow gets queue = number of slot ticks since the flow's birth, while that count is below 3. Flows born in the same slot always share a queue.
- R5: Once a flow has seen 3 or more slot ticks it gets queue 3, the lowest, forever. This includes ages of 16 ticks and more, where the 4-bit slot counter has wrapped.
- R6: A tick in the same cycle as an accepted packet counts before that packet is classified and before it is installed.
- R7: The key splits as index = `in_key[5:0]` and tag = `in_key[13:6]`. A packet that hits a valid entry with a different tag replaces that entry and is treated as a new flow (queue 0). The displaced flow is new again on its next packet.
- R8: `clear` high in a cycle empties the table, sets the slot count to 0 and ignores that cycle's tick. It also drops the packet presented in that cycle and the packet accepted one cycle earlier, so neither produces an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous table flush and slot restart |
| slot_tick | input | 1 | One-cycle pulse marking a slot boundary |
| in_valid | input | 1 | Packet present |
| in_key | input | 14 | Hashed flow key: {tag[7:0], index[5:0]} |
| out_valid | output | 1 | Classification result present |
| out_qid | output | 2 | Queue ID, 0 highest priority |

## Verification
A wrong birth slot or a missing tick shows up as a queue off by one on the next packet of that flow. This is visible two cycles after that packet enters. A failure to pin old flows stays hidden until a flow survives 16 ticks, when it falls back to a fast queue, so the tests let at least one flow live past a full counter wrap. A lost install, a wrong tag compare or a clear that fails to flush shows up as a queue other than 0 on the next packet of the affected index. Random traffic on a few indices with clashing tags stresses every such path while it is compared against an absolute-age model.

// File: rtl/fad_pkg.sv
`timescale 1ns/1ps
package fad_pkg;
   typedef enum logic [1:0] {
      LK_EMPTY = 2'd0,
      LK_ALIAS = 2'd1,
      LK_HIT   = 2'd2
   } lookup_e;
endpackage

// File: rtl/fad_slot_counter.sv
`timescale 1ns/1ps
module fad_slot_counter #(
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              slot_tick,
   output logic [SLOT_W-1:0] cur_slot,
   output logic [SLOT_W-1:0] eff_slot
);
   // slot number as seen by a packet arriving this cycle (tick applied first)
   assign eff_slot = slot_tick ? cur_slot + SLOT_W'(1) : cur_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cur_slot <= '0;
      else if (clear)  cur_slot <= '0;
      else             cur_slot <= eff_slot;
   end
endmodule

// File: rtl/fad_flow_table.sv
`timescale 1ns/1ps
module fad_flow_table
   import fad_pkg::*;
#(
   parameter int IDX_W   = 6,
   parameter int TAG_W   = 8,
   parameter int SLOT_W  = 4,
   parameter int AGE_LIM = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [SLOT_W-1:0] eff_slot,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  rd_tag,
   output lookup_e           rd_res,
   output logic [SLOT_W-1:0] rd_slot,
   output logic              rd_pinned,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0]  vld_a;
   logic [DEPTH-1:0]  pin_a;
   logic [TAG_W-1:0]  tag_a  [DEPTH];
   logic [SLOT_W-1:0] slot_a [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic              vld_q, pin_q;
      logic [TAG_W-1:0]  tag_q;
      logic [SLOT_W-1:0] slot_q;
      logic              install;
      logic [SLOT_W-1:0] slot_nx;
      logic [SLOT_W-1:0] age_nx;

      assign install = wr_en && (rd_idx == IDX_W'(i));
      assign slot_nx = install ? wr_slot : slot_q;
      // age the entry will have after this edge; pin it once it reaches the last queue
      assign age_nx  = eff_slot - slot_nx;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            pin_q  <= 1'b0;
            tag_q  <= '0;
            slot_q <= '0;
         end else if (clear) begin
            vld_q  <= 1'b0;
            pin_q  <= 1'b0;
         end else begin
            if (install) begin
               vld_q  <= 1'b1;
               tag_q  <= rd_tag;
               slot_q <= wr_slot;
            end
            pin_q <= (install ? 1'b0 : pin_q)
                     | ((install | vld_q) && (age_nx >= SLOT_W'(AGE_LIM)));
         end
      end

      assign vld_a[i]  = vld_q;
      assign pin_a[i]  = pin_q;
      assign tag_a[i]  = tag_q;
      assign slot_a[i] = slot_q;
   end

   always_comb begin
      rd_slot   = slot_a[rd_idx];
      rd_pinned = pin_a[rd_idx];
      if (!vld_a[rd_idx])                rd_res = LK_EMPTY;
      else if (tag_a[rd_idx] == rd_tag)  rd_res = LK_HIT;
      else                               rd_res = LK_ALIAS;
   end
endmodule

// File: rtl/fad_queue_map.sv
`timescale 1ns/1ps
module fad_queue_map
   import fad_pkg::*;
#(
   parameter int SLOT_W = 4,
   parameter int NUM_Q  = 4
) (
   input  lookup_e                     res,
   input  logic [SLOT_W-1:0]           ent_slot,
   input  logic                        ent_pinned,
   input  logic [SLOT_W-1:0]           pkt_slot,
   output logic [$clog2(NUM_Q)-1:0]    qid
);
   localparam int QID_W = $clog2(NUM_Q);
   localparam int LAST  = NUM_Q - 1;

   logic [SLOT_W-1:0] age;
   assign age = pkt_slot - ent_slot;

   always_comb begin
      if (res != LK_HIT)                              qid = '0;
      else if (ent_pinned || age >= SLOT_W'(LAST))    qid = QID_W'(LAST);
      else                                            qid = age[QID_W-1:0];
   end
endmodule

// File: rtl/flow_age_demoter.sv
`timescale 1ns/1ps
module flow_age_demoter
   import fad_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 8,
   parameter int SLOT_W = 4,
   parameter int NUM_Q  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       slot_tick,
   input  logic                       in_valid,
   input  logic [IDX_W+TAG_W-1:0]     in_key,
   output logic                       out_valid,
   output logic [$clog2(NUM_Q)-1:0]   out_qid
);
   localparam int KEY_W = IDX_W + TAG_W;
   localparam int QID_W = $clog2(NUM_Q);

   if (NUM_Q < 2) begin : g_bad_q
      $error("NUM_Q must be at least 2");
   end
   if ((1 << SLOT_W) < NUM_Q) begin : g_bad_slot
      $error("SLOT_W too narrow to reach the last queue before wrapping");
   end
   if (IDX_W < 1 || TAG_W < 1) begin : g_bad_key
      $error("IDX_W and TAG_W must be positive");
   end

   logic [SLOT_W-1:0] cur_slot, eff_slot;
   logic              s1_valid;
   logic [KEY_W-1:0]  s1_key;
   logic [SLOT_W-1:0] s1_slot;
   lookup_e           lk_res;
   logic [SLOT_W-1:0] lk_slot;
   logic              lk_pinned;
   logic [QID_W-1:0]  map_qid;
   logic              accept2;

   fad_slot_counter #(.SLOT_W(SLOT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clear(clear), .slot_tick(slot_tick),
      .cur_slot(cur_slot), .eff_slot(eff_slot)
   );

   // stage 1: capture key and the slot the packet arrived in
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_key   <= '0;
         s1_slot  <= '0;
      end else begin
         s1_valid <= in_valid && !clear;
         s1_key   <= in_key;
         s1_slot  <= eff_slot;
      end
   end

   assign accept2 = s1_valid && !clear;

   fad_flow_table #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W), .AGE_LIM(NUM_Q-1)
   ) u_tab (
      .clk(clk), .rst_n(rst_n), .clear(clear), .eff_slot(eff_slot),
      .rd_idx(s1_key[IDX_W-1:0]), .rd_tag(s1_key[KEY_W-1:IDX_W]),
      .rd_res(lk_res), .rd_slot(lk_slot), .rd_pinned(lk_pinned),
      .wr_en(accept2 && (lk_res != LK_HIT)), .wr_slot(s1_slot)
   );

   fad_queue_map #(.SLOT_W(SLOT_W), .NUM_Q(NUM_Q)) u_map (
      .res(lk_res), .ent_slot(lk_slot), .ent_pinned(lk_pinned),
      .pkt_slot(s1_slot), .qid(map_qid)
   );

   // stage 2: register the result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_qid   <= '0;
      end else begin
         out_valid <= accept2;
         out_qid   <= map_qid;
      end
   end
endmodule

// File: rtl/fad_checker.sv
`timescale 1ns/1ps
module fad_checker
   import fad_pkg::*;
#(
   parameter int SLOT_W = 4,
   parameter int QID_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear,
   input logic              slot_tick,
   input logic              in_valid,
   input logic              out_valid,
   input logic [QID_W-1:0]  out_qid,
   input logic [SLOT_W-1:0] cur_slot,
   input logic              s1_valid,
   input lookup_e           lk_res
);
   p_no_orphan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   p_lat_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(in_valid, 2) && !$past(clear, 2) && !$past(clear, 1))
      |-> out_valid);

   p_new_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !clear && lk_res != LK_HIT) |=> (out_qid == '0));

   p_tick_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_tick && !clear) |=> (cur_slot == $past(cur_slot) + SLOT_W'(1)));

   p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_tick && !clear) |=> $stable(cur_slot));

   p_flush_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !out_valid);

   p_flush_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cur_slot == '0));
endmodule

bind flow_age_demoter fad_checker #(.SLOT_W(SLOT_W), .QID_W(QID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .slot_tick(slot_tick),
   .in_valid(in_valid), .out_valid(out_valid), .out_qid(out_qid),
   .cur_slot(cur_slot), .s1_valid(s1_valid), .lk_res(lk_res)
);

// File: tb/tb_flow_age_demoter.sv
`timescale 1ns/1ps
module tb_flow_age_demoter;
   localparam int IDX_W = 6;
   localparam int TAG_W = 8;
   localparam int DEPTH = 64;
   localparam int LASTQ = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0;
   logic        slot_tick = 1'b0;
   logic        in_valid = 1'b0;
   logic [13:0] in_key = '0;
   logic        out_valid;
   logic [1:0]  out_qid;

   int checks = 0;
   int fails  = 0;
   bit running = 0;

   always #10 clk = ~clk;

   flow_age_demoter dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .slot_tick(slot_tick),
      .in_valid(in_valid), .in_key(in_key),
      .out_valid(out_valid), .out_qid(out_qid)
   );

   // behavioural model: absolute tick counts, no modular arithmetic
   int    now;
   bit    m_vld    [DEPTH];
   bit    m_killed [DEPTH];
   int    m_tag    [DEPTH];
   int    m_birth  [DEPTH];
   bit    e1_v, eo_v;
   int    e1_q, eo_q;
   string e1_r, eo_r;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now = 0;
         for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 0; m_killed[i] = 0;
         end
         e1_v <= 0; eo_v <= 0; e1_q <= 0; eo_q <= 0;
         e1_r <= "R1"; eo_r <= "R1";
      end else begin
         eo_v <= e1_v && !clear;
         eo_q <= e1_q;
         eo_r <= e1_r;
         if (clear) begin
            now = 0;
            for (int i = 0; i < DEPTH; i++) begin
               if (m_vld[i]) m_killed[i] = 1;
               m_vld[i] = 0;
            end
            e1_v <= 0;
         end else begin
            if (slot_tick) now++;
            if (in_valid) begin
               int idx, tg, age;
               idx = int'(in_key[5:0]);
               tg  = int'(in_key[13:6]);
               e1_v <= 1;
               if (m_vld[idx] && m_tag[idx] == tg) begin
                  age = now - m_birth[idx];
                  e1_q <= (age > LASTQ) ? LASTQ : age;
                  e1_r <= slot_tick ? "R6" : ((age >= LASTQ) ? "R5" : "R4");
               end else begin
                  e1_q <= 0;
                  e1_r <= m_vld[idx] ? "R7" : (m_killed[idx] ? "R8" : "R3");
                  m_vld[idx] = 1; m_killed[idx] = 0;
                  m_tag[idx] = tg; m_birth[idx] = now;
               end
            end else begin
               e1_v <= 0;
               e1_r <= "R2";
            end
         end
      end
   end

   always @(negedge clk) begin
      if (running && rst_n) begin
         checks++;
         if (out_valid !== eo_v || (eo_v && out_qid !== 2'(eo_q))) begin
            fails++;
            $display("FAIL %s: out_valid=%0b out_qid=%0d expected valid=%0b qid=%0d at %0t",
                     eo_v ? eo_r : "R2", out_valid, out_qid, eo_v, eo_q, $time);
         end
      end
   end

   task automatic drive(input bit v, input int key, input bit tk, input bit cl);
      in_valid  = v;
      in_key    = 14'(key);
      slot_tick = tk;
      clear     = cl;
      @(negedge clk);
   endtask

   function automatic int mk(input int tg, input int idx);
      return (tg << IDX_W) | idx;
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #3000000;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      summary();
   end

   initial begin
      int A, AX, B;
      A  = mk(8'h11, 5);
      AX = mk(8'h22, 5);
      B  = mk(8'h11, 9);
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: out_valid=%0b expected 0 in reset", out_valid);
      end
      rst_n = 1'b1;
      running = 1;
      @(negedge clk);
      // R1/R3: first packet new, then back-to-back hits (R2)
      drive(1, A, 0, 0); drive(1, A, 0, 0); drive(1, A, 0, 0);
      drive(0, 0, 1, 0); drive(1, A, 0, 0);          // R4 age 1
      drive(1, A, 1, 0);                             // R6 age 2
      drive(1, B, 0, 0);                             // R3 new in slot 2
      drive(0, 0, 1, 0); drive(0, 0, 1, 0);
      drive(1, A, 0, 0);                             // R5 age 4 -> 3
      drive(1, B, 0, 0);                             // R4 age 2
      repeat (20) drive(0, 0, 1, 0);
      drive(1, A, 0, 0);                             // R5 past wrap
      drive(1, B, 0, 0);
      drive(1, AX, 0, 0);                            // R7 alias replaces
      drive(1, A, 0, 0);                             // R7 displaced is new
      drive(1, A, 1, 0);
      drive(1, B, 0, 0); drive(1, A, 1, 1);          // R8 clear drops in-flight and current
      drive(1, B, 0, 0); drive(1, A, 0, 0);          // R8 new after flush
      drive(0, 0, 0, 0); drive(0, 0, 0, 0);
      // random traffic on few indices with clashing tags
      for (int n = 0; n < 5000; n++) begin
         int r;
         r = int'($urandom);
         drive(((r & 15) < 11), mk((r >> 4) & 3, (r >> 6) & 7),
               (((r >> 9) & 15) == 0), (((r >> 13) & 511) == 0));
      end
      repeat (4) drive(0, 0, 0, 0);
      running = 0;
      summary();
   end
endmodule